// File: doc/BRIEF.md
# Streaming Link Fragment Formatter

This block takes one data path's 32-bit elements and wraps them into a link fragment on a 32-bit output stream. A start-of-event pulse carries a bunch count and a buffer number. The block then emits the fragment in this order:

1. A descriptor word built from those values and three static configuration fields.
2. A timing word holding two latency stamps.
3. Every data element, unchanged and in arrival order.
4. A closing word that gives the element count and the error flags.

The element count goes at the end, so the block never waits for a whole event. Elements are forwarded as soon as they are accepted.

Latency is measured by a saturating cycle counter inside the block. The counter restarts on each accepted start-of-event pulse. The timing word carries two values:

- the current fragment's latency up to its first data element;
- the previous fragment's total latency, measured up to its closing word.

Both the input and output streams use valid/ready.

- **Input stream:** an element transfers on a clock edge where `in_valid` and `in_ready` are both high. The source must hold its element steady until then.
- **Output stream:** a word transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word and its valid stay unchanged.
- **Back-pressure:** a four-entry output queue absorbs stalls. `in_ready` drops whenever the queue is full, so no element is lost.
- **Control pins:** the start-of-event pins are plain, with no handshake.

Top module: `link_frag_fmt`

## Requirements
- R1: The first word of a fragment is {cfg_version[7:0] at bits 31:24, cfg_source[3:0] at 23:20, cfg_region[1:0] at 19:18, eight zero bits at 17:10, bunch count at 9:2, buffer number at 1:0}, using the values latched with the accepted start pulse.
- R2: The lower 16 bits of the second word give the current latency. This is the number of cycles from the accepted start pulse to the cycle in which the second word is queued. With the output draining, that is the first cycle the block waits in for data with `in_valid` high, at least 2 cycles after the pulse. The value saturates at 0xFFFF.
- R3: The upper 16 bits of the second word give the previous fragment's total latency. This is the cycle count from that fragment's start pulse to the cycle its closing word was queued, saturating at 0xFFFF. It is 0 for the first fragment after reset.
- R4: Data elements appear unchanged and in order. When the output queue is empty and `out_ready` is high, an element is on the output in the cycle right after the edge that accepted it.
- R5: The closing word carries the number of data elements in bits 31:16. Header and closing words are not counted.
- R6: A start pulse that arrives while a fragment is still open does not start a new fragment. Instead it sets bit 0 of the closing word's flag field (bits 15:0).
- R7: If an element arrives when the count is already 0xFFFF, the count stays at 0xFFFF and flag bit 1 is set. All other flag bits are zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No element is lost or duplicated under any pattern of `out_ready`.
- R9: After reset, `out_valid` and `in_ready` are low.
- R10: `in_ready` stays low from the accepted start pulse until the second word has been queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_version | input | 8 | Static format version |
| cfg_source | input | 4 | Static data-source code |
| cfg_region | input | 2 | Static region identifier |
| sev_strobe | input | 1 | Start-of-event pulse |
| sev_bunch | input | 8 | Bunch count, valid with the pulse |
| sev_bufnum | input | 2 | Buffer number, valid with the pulse |
| in_valid | input | 1 | Input element valid |
| in_data | input | 32 | Input element |
| in_last | input | 1 | Marks the final element of the event |
| in_ready | output | 1 | Block can accept an element |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output link word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The two saturation corners are the hardest states to reach from the ports: a latency count at 0xFFFF and an element count at 0xFFFF.

- For the latency corner, the bench holds back the first element for more than 65,535 cycles after a start pulse. It then confirms that the ceiling value appears in the current stamp, and again in the next fragment's previous stamp.
- For the count corner, it streams 65,536 elements back to back with the output always ready. This forces the count ceiling and the overflow flag.

Random `out_ready` patterns and input gaps keep the output queue full at times, which exercises the hold rule and the no-loss rule together.

// File: rtl/lff_pkg.sv
package lff_pkg;

  localparam int WORD_W  = 32;
  localparam int STAMP_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_WAIT,
    ST_DATA,
    ST_TAIL
  } frag_state_t;

  function automatic logic [WORD_W-1:0] pack_desc(
    input logic [7:0] ver,
    input logic [3:0] src,
    input logic [1:0] rgn,
    input logic [7:0] bunch,
    input logic [1:0] bufn
  );
    return {ver, src, rgn, 8'h00, bunch, bufn};
  endfunction

endpackage

// File: rtl/lff_sat_timer.sv
module lff_sat_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)              value <= '0;
    else if (restart)        value <= {{(W-1){1'b0}}, 1'b1};
    else if (value != TOP)   value <= value + 1'b1;
  end

  AST_LAT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (value == TOP && !restart) |=> (value == TOP)); // R2

endmodule

// File: rtl/lff_out_fifo.sv
module lff_out_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         space,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign space     = (count < CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH))); // R8

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_EMPTY_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !out_valid) |=> (out_valid && out_data == $past(push_data))); // R4

endmodule

// File: rtl/lff_framer.sv
module lff_framer
  import lff_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_version,
  input  logic [3:0]         cfg_source,
  input  logic [1:0]         cfg_region,
  input  logic               sev_strobe,
  input  logic [7:0]         sev_bunch,
  input  logic [1:0]         sev_bufnum,
  input  logic [STAMP_W-1:0] lat_now,
  output logic               timer_restart,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_last,
  output logic               in_ready,
  input  logic               fifo_space,
  output logic               push_valid,
  output logic [WORD_W-1:0]  push_data
);
  localparam logic [STAMP_W-1:0] CNT_TOP = {STAMP_W{1'b1}};

  frag_state_t        state;
  logic [7:0]         bunch_q;
  logic [1:0]         buf_q;
  logic [STAMP_W-1:0] prev_q, size_q;
  logic               ovl_q, ovf_q;
  logic               take;

  assign take = in_valid && in_ready;

  always_comb begin
    timer_restart = (state == ST_IDLE) && sev_strobe;
    in_ready      = (state == ST_DATA) && fifo_space;
    push_valid    = 1'b0;
    push_data     = '0;
    case (state)
      ST_HEAD: begin
        push_valid = fifo_space;
        push_data  = pack_desc(cfg_version, cfg_source, cfg_region, bunch_q, buf_q);
      end
      ST_WAIT: begin
        push_valid = fifo_space && in_valid;
        push_data  = {prev_q, lat_now};
      end
      ST_DATA: begin
        push_valid = take;
        push_data  = in_data;
      end
      ST_TAIL: begin
        push_valid = fifo_space;
        push_data  = {size_q, 14'b0, ovf_q, ovl_q | sev_strobe};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bunch_q <= '0;
      buf_q   <= '0;
      prev_q  <= '0;
      size_q  <= '0;
      ovl_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (sev_strobe && state != ST_IDLE) ovl_q <= 1'b1;
      case (state)
        ST_IDLE: if (sev_strobe) begin
          bunch_q <= sev_bunch;
          buf_q   <= sev_bufnum;
          size_q  <= '0;
          ovl_q   <= 1'b0;
          ovf_q   <= 1'b0;
          state   <= ST_HEAD;
        end
        ST_HEAD: if (fifo_space) state <= ST_WAIT;
        ST_WAIT: if (push_valid) state <= ST_DATA;
        ST_DATA: if (take) begin
          if (size_q == CNT_TOP) ovf_q <= 1'b1;
          else                   size_q <= size_q + 1'b1;
          if (in_last) state <= ST_TAIL;
        end
        ST_TAIL: if (fifo_space) begin
          prev_q <= lat_now;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_LOW_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sev_strobe) |=> !in_ready); // R10

  AST_OVERLAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (sev_strobe && (state == ST_HEAD || state == ST_WAIT || state == ST_DATA)) |=> ovl_q); // R6

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size_q == CNT_TOP) |=> (ovf_q && size_q == CNT_TOP)); // R7

endmodule

// File: rtl/link_frag_fmt.sv
module link_frag_fmt #(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_version,
  input  logic [3:0]  cfg_source,
  input  logic [1:0]  cfg_region,
  input  logic        sev_strobe,
  input  logic [7:0]  sev_bunch,
  input  logic [1:0]  sev_bufnum,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready
);
  import lff_pkg::*;

  logic [STAMP_W-1:0] lat_now;
  logic               timer_restart;
  logic               fifo_space;
  logic               push_valid;
  logic [WORD_W-1:0]  push_data;

  lff_sat_timer #(.W(STAMP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .value   (lat_now)
  );

  lff_framer u_framer (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_version   (cfg_version),
    .cfg_source    (cfg_source),
    .cfg_region    (cfg_region),
    .sev_strobe    (sev_strobe),
    .sev_bunch     (sev_bunch),
    .sev_bufnum    (sev_bufnum),
    .lat_now       (lat_now),
    .timer_restart (timer_restart),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_last       (in_last),
    .in_ready      (in_ready),
    .fifo_space    (fifo_space),
    .push_valid    (push_valid),
    .push_data     (push_data)
  );

  lff_out_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_valid),
    .push_data (push_data),
    .space     (fifo_space),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !in_ready)); // R9

endmodule

// File: tb/link_frag_fmt_test.sv
module link_frag_fmt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_version = 8'h3C;
  logic [3:0]  cfg_source = 4'h9;
  logic [1:0]  cfg_region = 2'h2;
  logic        sev_strobe = 1'b0;
  logic [7:0]  sev_bunch = '0;
  logic [1:0]  sev_bufnum = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;

  link_frag_fmt uut (.*);

  always #10 clk = ~clk;

  int unsigned checks = 0;
  int unsigned fails = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;
  bit          rdy_random = 1'b0;
  logic [31:0] out_q[$];
  int unsigned out_cyc_q[$];
  logic [31:0] sent_q[$];
  int unsigned first_acc = 0;
  bit          stall_prev = 1'b0;
  logic [31:0] stall_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor: decides out_ready and records handshakes away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(out_valid && out_data == stall_data, "R8 hold under stall", out_data, stall_data);
      out_ready = rdy_random ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        out_q.push_back(out_data);
        out_cyc_q.push_back(cyc);
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
    end
  end

  function automatic logic [31:0] desc_exp(input logic [7:0] b, input logic [1:0] n);
    logic [31:0] w;
    w = '0;
    w[31:24] = cfg_version;
    w[23:20] = cfg_source;
    w[19:18] = cfg_region;
    w[9:2]   = b;
    w[1:0]   = n;
    return w;
  endfunction

  task automatic send(input logic [31:0] d, input bit last);
    bit r;
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    forever begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // caller stands at a negedge; gap = cycles from pulse edge to first valid edge
  task automatic do_event(input logic [7:0] b, input logic [1:0] n, input int cnt,
                          input int gap, input bit overlap, input bit jitter, input bit chk_r10);
    logic [31:0] d;
    sent_q.delete();
    sev_strobe = 1'b1; sev_bunch = b; sev_bufnum = n;
    @(negedge clk);
    sev_strobe = 1'b0;
    if (chk_r10) chk(in_ready == 1'b0, "R10 ready low after start", {31'b0, in_ready}, 32'h0);
    repeat (gap - 1) @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      if (overlap && i == cnt / 2) begin
        sev_strobe = 1'b1;
        @(negedge clk);
        sev_strobe = 1'b0;
      end
      if (jitter) repeat ($urandom_range(0, 2)) @(negedge clk);
      d = $urandom;
      sent_q.push_back(d);
      send(d, i == cnt - 1);
      if (i == 0) first_acc = cyc;
    end
  endtask

  task automatic check_frag(input logic [7:0] b, input logic [1:0] n, input logic [15:0] flags,
                            output logic [15:0] got_prev, output logic [15:0] got_cur,
                            output int unsigned data0_cyc);
    int unsigned need;
    logic [31:0] w;
    logic [15:0] sz;
    need = sent_q.size() + 3;
    while (out_q.size() < need) @(negedge clk);
    w = out_q.pop_front(); void'(out_cyc_q.pop_front());
    chk(w == desc_exp(b, n), "R1 descriptor word", w, desc_exp(b, n));
    w = out_q.pop_front(); void'(out_cyc_q.pop_front());
    got_prev = w[31:16];
    got_cur  = w[15:0];
    data0_cyc = out_cyc_q[0];
    foreach (sent_q[i]) begin
      w = out_q.pop_front(); void'(out_cyc_q.pop_front());
      chk(w == sent_q[i], "R4 data word order", w, sent_q[i]);
    end
    w = out_q.pop_front(); void'(out_cyc_q.pop_front());
    sz = (sent_q.size() > 65535) ? 16'hFFFF : 16'(sent_q.size());
    chk(w[31:16] == sz, "R5 element count", {16'b0, w[31:16]}, {16'b0, sz});
    chk(w[15:0] == flags, "R6/R7 flag field", {16'b0, w[15:0]}, {16'b0, flags});
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] pv, cv;
    int unsigned c0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", {31'b0, out_valid}, 32'h0);
    chk(in_ready == 1'b0, "R9 reset in_ready", {31'b0, in_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: latency 5, three elements, total 5+3+1 = 9
    do_event(8'hA5, 2'd2, 3, 5, 1'b0, 1'b0, 1'b1);
    check_frag(8'hA5, 2'd2, 16'h0, pv, cv, c0);
    chk(cv == 16'd5, "R2 current latency", {16'b0, cv}, 32'd5);
    chk(pv == 16'd0, "R3 previous latency after reset", {16'b0, pv}, 32'd0);
    chk(c0 == first_acc, "R4 one-cycle pass-through", c0, first_acc);

    do_event(8'h11, 2'd1, 1, 3, 1'b0, 1'b0, 1'b0);
    check_frag(8'h11, 2'd1, 16'h0, pv, cv, c0);
    chk(cv == 16'd3, "R2 current latency short", {16'b0, cv}, 32'd3);
    chk(pv == 16'd9, "R3 previous total latency", {16'b0, pv}, 32'd9);

    // R6: extra pulse mid-fragment is flagged and opens nothing
    do_event(8'h42, 2'd3, 6, 2, 1'b1, 1'b0, 1'b0);
    check_frag(8'h42, 2'd3, 16'h0001, pv, cv, c0);
    repeat (20) @(negedge clk);
    chk(out_q.size() == 0, "R6 no fragment from ignored pulse", out_q.size(), 0);

    // random back-pressure and input gaps
    rdy_random = 1'b1;
    for (int e = 0; e < 25; e++) begin
      logic [7:0] b;
      logic [1:0] n;
      b = 8'($urandom);
      n = 2'($urandom);
      cfg_version = 8'($urandom);
      do_event(b, n, $urandom_range(1, 12), $urandom_range(2, 6), 1'b0, 1'b1, 1'b0);
      check_frag(b, n, 16'h0, pv, cv, c0);
    end
    rdy_random = 1'b0;
    repeat (4) @(negedge clk);

    // R2 saturation of the current stamp
    do_event(8'h07, 2'd0, 2, 65600, 1'b0, 1'b0, 1'b0);
    check_frag(8'h07, 2'd0, 16'h0, pv, cv, c0);
    chk(cv == 16'hFFFF, "R2 latency saturates", {16'b0, cv}, 32'hFFFF);

    // R7 count ceiling; also R3 carries saturated total
    do_event(8'h99, 2'd1, 65536, 2, 1'b0, 1'b0, 1'b0);
    check_frag(8'h99, 2'd1, 16'h0002, pv, cv, c0);
    chk(pv == 16'hFFFF, "R3 saturated previous total", {16'b0, pv}, 32'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule